// File: doc/BRIEF.md
# RGB to YCbCr Pixel Converter

This block turns one pixel of three 8-bit colour channels into one luma value and two colour-difference values. It uses studio-swing weights scaled by 256. The caller presents a pixel together with an input valid strobe. The converted pixel appears with an output valid strobe exactly two clock cycles later. A new pixel may be presented on every cycle, and idle cycles pass through the pipeline as bubbles.

Each output is a weighted sum of the three channels. The nine constant-times-pixel products are formed by radix-4 Booth multipliers and registered. In the second stage, each component's three products and one constant addend are reduced by two levels of 3:2 carry-save compressors. A single ripple-carry adder of parameter width then resolves the sum. The constant addend combines the rounding term 128 with the output bias shifted up by 8 bits. The resolved value is shifted right by 8 bits and clamped to 0..255.

Top module: `rgb2ycc_conv`

## Requirements
- R1: out_y equals floor((66*R + 129*G + 25*B + 128) / 256) + 16 for the pixel that was accepted two cycles earlier.
- R2: out_cb equals floor((112*B - 38*R - 74*G + 128) / 256) + 128 for that pixel, with floor rounding toward minus infinity.
- R3: out_cr equals floor((112*R - 94*G - 18*B + 128) / 256) + 128 for that pixel, with floor rounding toward minus infinity.
- R4: out_valid is high in a cycle exactly when in_valid was high two rising edges earlier. This holds for back-to-back pixels and for bubbles, and each output valid pulse lasts one cycle per input pixel.
- R5: While rst is high, and afterwards until a pixel is accepted with rst low, out_valid stays low. A pixel accepted in the cycle just before reset is discarded.
- R6: Every output is clamped to 0..255. For 8-bit inputs, out_y lies in 16..235, and out_cb and out_cr lie in 16..240.
- R7: A grey pixel (R = G = B) yields out_cb = 128 and out_cr = 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, clears the valid pipeline |
| in_valid | input | 1 | Pixel on in_r/in_g/in_b is accepted at this edge |
| in_r | input | 8 | Red channel, unsigned |
| in_g | input | 8 | Green channel, unsigned |
| in_b | input | 8 | Blue channel, unsigned |
| out_valid | output | 1 | out_y/out_cb/out_cr hold a converted pixel |
| out_y | output | 8 | Luma |
| out_cb | output | 8 | Blue colour difference |
| out_cr | output | 8 | Red colour difference |

## Verification
A pixel driven before rising edge k is registered as products at edge k. Its Y, Cb, Cr and valid are all registered at edge k+1, so every result is due two edges after its stimulus. The bench drives on falling edges and samples on the falling edge that follows the second rising edge. It also confirms that out_valid is still low one falling edge earlier. For streamed and bubbled input, the bench compares each falling edge against the pixel and valid bit it drove two falling edges before.

// File: rtl/rgb2ycc_pkg.sv
package rgb2ycc_pkg;

    localparam int PIX_W  = 8;
    localparam int COEF_W = 9;
    localparam int ACC_W  = 18;
    localparam int FRAC_W = 8;
    localparam int NCOMP  = 3;
    localparam int NCHAN  = 3;
    localparam int PIX_MAX = (1 << PIX_W) - 1;

    localparam int IDX_Y  = 0;
    localparam int IDX_CB = 1;
    localparam int IDX_CR = 2;

    typedef logic [PIX_W-1:0]         pix_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef struct packed {
        logic                                   vld;
        logic [NCOMP-1:0][NCHAN-1:0][ACC_W-1:0] prod;
    } prod_stage_t;

    typedef struct packed {
        logic                  vld;
        logic [NCOMP-1:0][PIX_W-1:0] comp;
    } out_stage_t;

    // weight of channel chan (0 red, 1 green, 2 blue) in component comp
    function automatic coef_t weight(input int comp, input int chan);
        case (comp * NCHAN + chan)
            0: return coef_t'(66);
            1: return coef_t'(129);
            2: return coef_t'(25);
            3: return coef_t'(-38);
            4: return coef_t'(-74);
            5: return coef_t'(112);
            6: return coef_t'(112);
            7: return coef_t'(-94);
            8: return coef_t'(-18);
            default: return coef_t'(0);
        endcase
    endfunction

    // rounding half plus output bias placed above the fraction bits
    function automatic acc_t const_addend(input int comp);
        int bias;
        bias = (comp == IDX_Y) ? 16 : 128;
        return acc_t'((1 << (FRAC_W - 1)) + (bias << FRAC_W));
    endfunction

    function automatic pix_t saturate(input acc_t v);
        if (v < 0)
            return '0;
        else if (v > acc_t'(PIX_MAX))
            return '1;
        else
            return v[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/booth_r4_mul.sv
module booth_r4_mul #(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 9,
    parameter int OUT_W  = 18
) (
    input  logic [PIX_W-1:0]         mplier,
    input  logic signed [COEF_W-1:0] mcand,
    output logic signed [OUT_W-1:0]  product
);
    // unsigned multiplier: zero-extend so the top group never reads a sign
    localparam int NGRP = (PIX_W + 2) / 2;
    localparam int XW   = 2 * NGRP + 1;

    logic [XW-1:0]            xe;
    logic signed [OUT_W-1:0]  m1;
    logic signed [OUT_W-1:0]  m2;
    logic signed [OUT_W-1:0]  pp [NGRP];

    assign xe = {{(XW - PIX_W - 1){1'b0}}, mplier, 1'b0};
    assign m1 = {{(OUT_W - COEF_W){mcand[COEF_W-1]}}, mcand};
    assign m2 = m1 <<< 1;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic signed [OUT_W-1:0] digit_pp;
        always_comb begin
            case (xe[2*g+2 -: 3])
                3'b001, 3'b010: digit_pp = m1;
                3'b011:         digit_pp = m2;
                3'b100:         digit_pp = -m2;
                3'b101, 3'b110: digit_pp = -m1;
                default:        digit_pp = '0;
            endcase
        end
        assign pp[g] = digit_pp <<< (2 * g);
    end

    always_comb begin
        product = '0;
        for (int g = 0; g < NGRP; g++)
            product = product + pp[g];
    end

endmodule

// File: rtl/csa_3to2.sv
module csa_3to2 #(
    parameter int W = 18
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] sum,
    output logic [W-1:0] carry
);
    // carry bit 0 is empty, so the next level sees only two live inputs there
    assign carry[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i] = a[i] ^ b[i] ^ c[i];
        if (i < W - 1) begin : g_cy
            assign carry[i+1] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
        end
    end

endmodule

// File: rtl/rca_adder.sv
module rca_adder #(
    parameter int W = 18
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    logic [W-1:0] cy;

    assign cy[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum[i] = a[i] ^ b[i] ^ cy[i];
        if (i < W - 1) begin : g_cy
            assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
        end
    end

endmodule

// File: rtl/rgb2ycc_conv.sv
module rgb2ycc_conv
    import rgb2ycc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_r,
    input  logic [PIX_W-1:0] in_g,
    input  logic [PIX_W-1:0] in_b,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_y,
    output logic [PIX_W-1:0] out_cb,
    output logic [PIX_W-1:0] out_cr
);

    pix_t        chan_in [NCHAN];
    acc_t        prod_c  [NCOMP][NCHAN];
    prod_stage_t s1;
    out_stage_t  s2;
    logic [NCOMP-1:0][PIX_W-1:0] comp_nx;

    assign chan_in[0] = in_r;
    assign chan_in[1] = in_g;
    assign chan_in[2] = in_b;

    // stage 1: nine constant-by-pixel Booth products
    for (genvar k = 0; k < NCOMP; k++) begin : g_comp_mul
        for (genvar c = 0; c < NCHAN; c++) begin : g_chan
            localparam coef_t KC = weight(k, c);
            booth_r4_mul #(
                .PIX_W (PIX_W),
                .COEF_W(COEF_W),
                .OUT_W (ACC_W)
            ) u_mul (
                .mplier (chan_in[c]),
                .mcand  (KC),
                .product(prod_c[k][c])
            );
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            s1.vld <= 1'b0;
        else
            s1.vld <= in_valid;
        for (int k = 0; k < NCOMP; k++)
            for (int c = 0; c < NCHAN; c++)
                s1.prod[k][c] <= prod_c[k][c];
    end

    // stage 2: 4 addends -> two 3:2 levels -> one ripple adder -> shift, clamp
    for (genvar k = 0; k < NCOMP; k++) begin : g_comp_sum
        localparam acc_t KOFF = const_addend(k);
        logic [ACC_W-1:0] sum_a, cy_a, sum_b, cy_b, total;
        acc_t             scaled;

        csa_3to2 #(.W(ACC_W)) u_csa_lvl0 (
            .a    (s1.prod[k][0]),
            .b    (s1.prod[k][1]),
            .c    (s1.prod[k][2]),
            .sum  (sum_a),
            .carry(cy_a)
        );

        csa_3to2 #(.W(ACC_W)) u_csa_lvl1 (
            .a    (sum_a),
            .b    (cy_a),
            .c    (KOFF),
            .sum  (sum_b),
            .carry(cy_b)
        );

        rca_adder #(.W(ACC_W)) u_rca (
            .a  (sum_b),
            .b  (cy_b),
            .sum(total)
        );

        assign scaled     = $signed(total) >>> FRAC_W;
        assign comp_nx[k] = saturate(scaled);
    end

    always_ff @(posedge clk) begin
        if (rst)
            s2.vld <= 1'b0;
        else
            s2.vld <= s1.vld;
        s2.comp <= comp_nx;
    end

    assign out_valid = s2.vld;
    assign out_y     = s2.comp[IDX_Y];
    assign out_cb    = s2.comp[IDX_CB];
    assign out_cr    = s2.comp[IDX_CR];

endmodule

// File: rtl/rgb2ycc_chk.sv
module rgb2ycc_chk
    import rgb2ycc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [PIX_W-1:0] in_r,
    input logic [PIX_W-1:0] in_g,
    input logic [PIX_W-1:0] in_b,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_y,
    input logic [PIX_W-1:0] out_cb,
    input logic [PIX_W-1:0] out_cr
);
    logic vld_d1, vld_d2;
    logic gray_d1, gray_d2;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_d1 <= 1'b0;
            vld_d2 <= 1'b0;
        end else begin
            vld_d1 <= in_valid;
            vld_d2 <= vld_d1;
        end
        gray_d1 <= (in_r == in_g) && (in_g == in_b);
        gray_d2 <= gray_d1;
    end

    // R4: two-edge latency of the valid strobe
    assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid == vld_d2);

    // R5: reset empties the pipeline
    assert_reset_clears_R5: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R6: output ranges
    assert_y_range_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_y >= 8'd16 && out_y <= 8'd235));

    assert_c_range_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_cb >= 8'd16 && out_cb <= 8'd240 &&
                       out_cr >= 8'd16 && out_cr <= 8'd240));

    // R7: grey gives neutral chroma
    assert_gray_neutral_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && gray_d2) |-> (out_cb == 8'd128 && out_cr == 8'd128));

endmodule

bind rgb2ycc_conv rgb2ycc_chk u_chk (.*);

// File: tb/tb_rgb2ycc_conv.sv
module tb_rgb2ycc_conv;

    localparam int CLK_PERIOD = 10;
    localparam int NSTREAM    = 48;
    localparam int NVEC       = 5;

    // {r, g, b, y, cb, cr}
    localparam logic [47:0] VEC [NVEC] = '{
        {8'd0,   8'd0,   8'd0,   8'd16,  8'd128, 8'd128},
        {8'd255, 8'd255, 8'd255, 8'd235, 8'd128, 8'd128},
        {8'd255, 8'd0,   8'd0,   8'd82,  8'd90,  8'd240},
        {8'd0,   8'd255, 8'd0,   8'd144, 8'd54,  8'd34},
        {8'd0,   8'd0,   8'd255, 8'd41,  8'd240, 8'd110}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [7:0] in_r, in_g, in_b;
    logic       out_valid;
    logic [7:0] out_y, out_cb, out_cr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rgb2ycc_conv dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
    );

    function automatic int clamp8(input int v);
        return (v < 0) ? 0 : ((v > 255) ? 255 : v);
    endfunction
    function automatic int mdl_y(input int r, input int g, input int b);
        return clamp8(((66*r + 129*g + 25*b + 128) >>> 8) + 16);
    endfunction
    function automatic int mdl_cb(input int r, input int g, input int b);
        return clamp8(((112*b - 38*r - 74*g + 128) >>> 8) + 128);
    endfunction
    function automatic int mdl_cr(input int r, input int g, input int b);
        return clamp8(((112*r - 94*g - 18*b + 128) >>> 8) + 128);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic one_pixel(input int r, input int g, input int b,
                             input int ey, input int ecb, input int ecr);
        in_r = 8'(r); in_g = 8'(g); in_b = 8'(b); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R4 out_valid not yet after one edge", int'(out_valid), 0);
        @(negedge clk);
        chk("R4 out_valid after two edges", int'(out_valid), 1);
        chk("R1 luma", int'(out_y), ey);
        chk("R2 blue difference", int'(out_cb), ecb);
        chk("R3 red difference", int'(out_cr), ecr);
        @(negedge clk);
        chk("R4 single pulse", int'(out_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R4 watchdog actual=hung expected=finished");
        finish_run();
    end

    logic [23:0] spix [NSTREAM];
    int seed;
    logic [7:0] bubble_pat;

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_r = '0; in_g = '0; in_b = '0;
        repeat (3) @(negedge clk);
        chk("R5 out_valid during reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R5 out_valid after release", int'(out_valid), 0);
        @(negedge clk);
        chk("R5 out_valid idle", int'(out_valid), 0);

        // table of vectors with hand-worked results (R1 R2 R3 R4)
        for (int i = 0; i < NVEC; i++) begin
            one_pixel(int'(VEC[i][47:40]), int'(VEC[i][39:32]), int'(VEC[i][31:24]),
                      int'(VEC[i][23:16]), int'(VEC[i][15:8]), int'(VEC[i][7:0]));
        end

        // back-to-back stream against the formulas (R1 R2 R3 R4 R6)
        seed = 32'h1234_5678;
        for (int i = 0; i < NSTREAM; i++) begin
            seed = seed * 1103515245 + 12345;
            spix[i] = seed[30:7];
        end
        for (int i = 0; i < NSTREAM + 2; i++) begin
            if (i >= 2) begin
                int r, g, b;
                r = int'(spix[i-2][23:16]); g = int'(spix[i-2][15:8]); b = int'(spix[i-2][7:0]);
                chk("R4 stream valid", int'(out_valid), 1);
                chk("R1 stream luma", int'(out_y), mdl_y(r, g, b));
                chk("R2 stream cb", int'(out_cb), mdl_cb(r, g, b));
                chk("R3 stream cr", int'(out_cr), mdl_cr(r, g, b));
                chk("R6 stream luma range", int'(out_y >= 8'd16 && out_y <= 8'd235), 1);
            end
            if (i < NSTREAM) begin
                {in_r, in_g, in_b} = spix[i];
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end
        chk("R4 stream drained", int'(out_valid), 0);

        // grey ramp (R7)
        for (int i = 0; i < 8; i++) begin
            int v;
            v = (i == 7) ? 255 : i * 37;
            in_r = 8'(v); in_g = 8'(v); in_b = 8'(v); in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            @(negedge clk);
            chk("R7 grey cb", int'(out_cb), 128);
            chk("R7 grey cr", int'(out_cr), 128);
            chk("R1 grey luma", int'(out_y), mdl_y(v, v, v));
        end
        @(negedge clk);

        // bubbles: out_valid repeats in_valid two edges later (R4)
        bubble_pat = 8'b1011_0010;
        for (int i = 0; i < 10; i++) begin
            if (i >= 2)
                chk("R4 bubble pattern", int'(out_valid), int'(bubble_pat[i-2]));
            in_valid = (i < 8) ? bubble_pat[i] : 1'b0;
            in_r = 8'(i * 20); in_g = 8'(200 - i * 9); in_b = 8'(i * 3);
            @(negedge clk);
        end

        // pixel accepted just before reset must vanish (R5)
        in_r = 8'd10; in_g = 8'd20; in_b = 8'd30; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        chk("R5 flushed in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R5 flushed after reset 1", int'(out_valid), 0);
        @(negedge clk);
        chk("R5 flushed after reset 2", int'(out_valid), 0);

        // pipeline works again after reset (R1 R2 R3)
        one_pixel(10, 20, 30, mdl_y(10, 20, 30), mdl_cb(10, 20, 30), mdl_cr(10, 20, 30));

        finish_run();
    end

endmodule